// File: doc/BRIEF.md
# Endpoint-Zero Control/Status Register

This block holds the software-visible control and status byte for a USB device's default control endpoint, together with a byte that holds the IN packet size. Firmware reaches both through a one-cycle register write port and a combinational read port. The packet engine reaches the same flags through single-cycle event strobes. Each flag in the status byte has its own set and clear rule. Some are commands that clear themselves. Some are status bits that firmware clears with a strobe. One is a sticky flag that only firmware can clear. Others are handshake bits that hardware clears.

Every flag is a register, so an event or a write sampled at clock edge k is visible from edge k onward. Two pulses are also registered: the endpoint interrupt and the FIFO flush. Each is high for the single cycle after the edge that sampled its cause. When a hardware set event and a firmware clear arrive in the same cycle, the set wins. The STALL request and the STALL-sent flag form a four-state machine:
- STL_IDLE: no request and no flag.
- STL_ARMED: a request is pending.
- STL_HELD: the sent flag is held.
- STL_BOTH: a new request is pending while the old sent flag is still held.

Its transitions are:
- arm: firmware writes send-stall.
- transmit: the stall-sent event arrives. It moves ARMED or BOTH to HELD, or to BOTH when the same cycle also re-arms.
- acknowledge: firmware writes 0 to sent-stall. It moves HELD to IDLE and BOTH to ARMED.

Top module: `ep0_ctrl_status`

## Requirements
- R1: After reset the status byte reads 0x00 and the packet-size byte reads 0x00. `stall_req`, `in_pkt_rdy`, `data_end`, `fifo_flush` and `ep_irq` are all low.
- R2: With `reg_sel`=0, `reg_rdata` reads as follows:
  - bit 7 = 0 and bit 6 = 0 (the two clear commands).
  - bit 5 = send-stall.
  - bit 4 = setup-end.
  - bit 3 = data-end.
  - bit 2 = sent-stall.
  - bit 1 = in-packet-ready.
  - bit 0 = out-packet-ready.
- R3: A status write with bit 7 = 1 clears setup-end. A status write with bit 6 = 1 clears out-packet-ready.
- R4: A status write with bit 5 = 1 sets send-stall, which drives `stall_req`. `ev_stall_sent` clears it, unless the same cycle writes bit 5 = 1 again.
- R5: `ev_setup_abort` sets setup-end and gives a one-cycle `fifo_flush` pulse. A write to bit 4 has no effect.
- R6: A status write with bit 3 = 1 sets data-end. `ev_data_done` clears it, and a firmware set in the same cycle wins.
- R7: `ev_stall_sent` sets sent-stall. A status write with bit 2 = 0 clears it. A write with bit 2 = 1 leaves it unchanged.
- R8: A status write with bit 1 = 1 sets in-packet-ready. `ev_in_sent` clears it, and a firmware set in the same cycle wins.
- R9: `ev_out_rcvd` sets out-packet-ready. A write to bit 0 has no effect.
- R10: When a hardware set event and a firmware clear hit the same flag in one cycle, the flag ends up set. This applies to setup-end, out-packet-ready and sent-stall.
- R11: `ep_irq` is high for exactly the cycle after any cycle that carries at least one of these events: `ev_setup_abort`, `ev_stall_sent`, `ev_in_sent`, `ev_out_rcvd`. Several events in one cycle give one pulse.
- R12: A write with `reg_sel`=1 loads the packet-size byte, in units of 8 bytes. It appears on `max_pkt` and on `reg_rdata` when `reg_sel`=1. A status write does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status byte, 1 = packet-size byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected byte |
| ev_setup_abort | input | 1 | Control transfer ended early |
| ev_stall_sent | input | 1 | STALL handshake transmitted |
| ev_in_sent | input | 1 | IN packet transmitted |
| ev_out_rcvd | input | 1 | OUT packet placed in FIFO |
| ev_data_done | input | 1 | Controller consumed data-end |
| stall_req | output | 1 | Answer the next transfer with STALL |
| in_pkt_rdy | output | 1 | IN packet loaded and ready |
| data_end | output | 1 | Last packet of the data stage |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| ep_irq | output | 1 | One-cycle endpoint interrupt pulse |
| max_pkt | output | 8 | IN packet size in units of 8 bytes |

## Verification
Every flag result is due at the first clock edge that samples its cause. The `fifo_flush` and `ep_irq` pulses are due in the same cycle that the flags update, and they fall one edge later. `reg_rdata` follows `reg_sel` in the same cycle without any register. The bench drives inputs 2 ns after a rising edge. It advances a behavioural model on each rising edge and compares every output at the falling edge. Directed checks read the ports 2 ns after the edge that consumed a stimulus, and that is the cycle in which the result is due.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
    localparam int REG_W        = 8;
    // bit positions of the status byte; the order is part of the register contract
    localparam int B_CLR_SETUP  = 7;
    localparam int B_CLR_OUT    = 6;
    localparam int B_SEND_STALL = 5;
    localparam int B_SETUP_END  = 4;
    localparam int B_DATA_END   = 3;
    localparam int B_SENT_STALL = 2;
    localparam int B_IN_RDY     = 1;
    localparam int B_OUT_RDY    = 0;

    // index of each hardware-handshake flag inside the flag bank
    localparam int F_SETUP      = 0;
    localparam int F_OUT        = 1;
    localparam int F_DEND       = 2;
    localparam int F_INRDY      = 3;
    localparam int NFLAG        = 4;

    // index of each interrupt source
    localparam int NIRQ         = 4;

    // stall machine: bit0 = request pending, bit1 = sent flag held
    typedef enum logic [1:0] {
        STL_IDLE  = 2'b00,
        STL_ARMED = 2'b01,
        STL_HELD  = 2'b10,
        STL_BOTH  = 2'b11
    } stall_state_t;
endpackage

// File: rtl/ep0_hs_flag.sv
module ep0_hs_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assign q_o = q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o) else $error("flag lost a set event"); // R10

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o) else $error("flag clear ignored"); // R3
endmodule

// File: rtl/ep0_stall_fsm.sv
module ep0_stall_fsm
    import ep0_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fw_arm,
    input  logic fw_clr_sent,
    input  logic hw_sent,
    output logic stall_req,
    output logic sent_flag
);
    stall_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= STL_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            STL_IDLE: begin
                if (hw_sent)     nxt = fw_arm ? STL_BOTH : STL_HELD;
                else if (fw_arm) nxt = STL_ARMED;
            end
            STL_ARMED: begin
                if (hw_sent)     nxt = fw_arm ? STL_BOTH : STL_HELD;
            end
            STL_HELD: begin
                if (hw_sent)          nxt = fw_arm ? STL_BOTH : STL_HELD;
                else if (fw_clr_sent) nxt = fw_arm ? STL_ARMED : STL_IDLE;
                else if (fw_arm)      nxt = STL_BOTH;
            end
            STL_BOTH: begin
                if (hw_sent)          nxt = fw_arm ? STL_BOTH : STL_HELD;
                else if (fw_clr_sent) nxt = STL_ARMED;
            end
            default: nxt = STL_IDLE;
        endcase
    end

    always_comb begin
        stall_req = 1'b0;
        sent_flag = 1'b0;
        unique case (state)
            STL_IDLE:  ;
            STL_ARMED: stall_req = 1'b1;
            STL_HELD:  sent_flag = 1'b1;
            STL_BOTH:  begin stall_req = 1'b1; sent_flag = 1'b1; end
            default:   ;
        endcase
    end

    AST_STALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_sent && !fw_arm) |=> !stall_req) else $error("stall request kept"); // R4

    AST_STALL_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        fw_arm |=> stall_req) else $error("stall request missed"); // R4

    AST_SENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hw_sent |=> sent_flag) else $error("sent flag lost"); // R7

    AST_SENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_flag && !fw_clr_sent) |=> sent_flag) else $error("sent flag dropped"); // R7
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen
    import ep0_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] ev_i,
    input  logic            abort_i,
    output logic            irq_o,
    output logic            flush_o
);
    logic irq_q, flush_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            irq_q   <= |ev_i;
            flush_q <= abort_i;
        end
    end

    assign irq_o   = irq_q;
    assign flush_o = flush_q;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|ev_i) |=> !irq_o) else $error("spurious interrupt"); // R11

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> irq_o) else $error("interrupt missed"); // R11

    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> flush_o) else $error("flush missed"); // R5
endmodule

// File: rtl/ep0_ctrl_status.sv
module ep0_ctrl_status
    import ep0_pkg::*;
#(
    parameter int MPS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ev_setup_abort,
    input  logic             ev_stall_sent,
    input  logic             ev_in_sent,
    input  logic             ev_out_rcvd,
    input  logic             ev_data_done,
    output logic             stall_req,
    output logic             in_pkt_rdy,
    output logic             data_end,
    output logic             fifo_flush,
    output logic             ep_irq,
    output logic [MPS_W-1:0] max_pkt
);
    localparam int PAD_W = (REG_W > MPS_W) ? REG_W - MPS_W : 1;

    logic             wr_cs, wr_mps;
    logic [NFLAG-1:0] set_v, clr_v, q_v;
    logic             sent_flag;
    logic [MPS_W-1:0] mps_q;

    assign wr_cs  = reg_wr & ~reg_sel;
    assign wr_mps = reg_wr &  reg_sel;

    // per-flag set and clear sources; a set always wins inside the flag cell
    assign set_v[F_SETUP] = ev_setup_abort;
    assign clr_v[F_SETUP] = wr_cs & reg_wdata[B_CLR_SETUP];
    assign set_v[F_OUT]   = ev_out_rcvd;
    assign clr_v[F_OUT]   = wr_cs & reg_wdata[B_CLR_OUT];
    assign set_v[F_DEND]  = wr_cs & reg_wdata[B_DATA_END];
    assign clr_v[F_DEND]  = ev_data_done;
    assign set_v[F_INRDY] = wr_cs & reg_wdata[B_IN_RDY];
    assign clr_v[F_INRDY] = ev_in_sent;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        ep0_hs_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q_o   (q_v[i])
        );
    end

    ep0_stall_fsm u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .fw_arm      (wr_cs & reg_wdata[B_SEND_STALL]),
        .fw_clr_sent (wr_cs & ~reg_wdata[B_SENT_STALL]),
        .hw_sent     (ev_stall_sent),
        .stall_req   (stall_req),
        .sent_flag   (sent_flag)
    );

    ep0_irq_gen u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    ({ev_out_rcvd, ev_in_sent, ev_stall_sent, ev_setup_abort}),
        .abort_i (ev_setup_abort),
        .irq_o   (ep_irq),
        .flush_o (fifo_flush)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      mps_q <= '0;
        else if (wr_mps) mps_q <= reg_wdata[MPS_W-1:0];
    end

    assign max_pkt    = mps_q;
    assign in_pkt_rdy = q_v[F_INRDY];
    assign data_end   = q_v[F_DEND];

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[MPS_W-1:0] = mps_q;
        end else begin
            reg_rdata[B_SEND_STALL] = stall_req;
            reg_rdata[B_SETUP_END]  = q_v[F_SETUP];
            reg_rdata[B_DATA_END]   = q_v[F_DEND];
            reg_rdata[B_SENT_STALL] = sent_flag;
            reg_rdata[B_IN_RDY]     = q_v[F_INRDY];
            reg_rdata[B_OUT_RDY]    = q_v[F_OUT];
        end
    end

    logic [PAD_W-1:0] unused_pad;
    assign unused_pad = '0;

    AST_OUT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cs && !ev_out_rcvd && !q_v[F_OUT]) |=> !q_v[F_OUT]) else $error("firmware set out-ready"); // R9

    AST_SETUP_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cs && !ev_setup_abort && !q_v[F_SETUP]) |=> !q_v[F_SETUP]) else $error("firmware set setup-end"); // R5

    AST_MPS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mps |=> (max_pkt == $past(reg_wdata[MPS_W-1:0]))) else $error("size byte not loaded"); // R12

    AST_MPS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mps |=> $stable(max_pkt)) else $error("size byte changed"); // R12

    AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[B_CLR_SETUP] == 1'b0 && reg_rdata[B_CLR_OUT] == 1'b0)) else $error("command bit read back"); // R2
endmodule

// File: tb/tb_ep0_ctrl_status.sv
`timescale 1ns/1ps
module tb_ep0_ctrl_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic ev_setup_abort = 0, ev_stall_sent = 0, ev_in_sent = 0, ev_out_rcvd = 0, ev_data_done = 0;
    logic stall_req, in_pkt_rdy, data_end, fifo_flush, ep_irq;
    logic [7:0] max_pkt;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit cmp_on = 0;

    // behavioural reference state
    bit m_send, m_setup, m_dend, m_sent, m_in, m_out, m_irq, m_flush;
    int m_mps;

    always #5 clk = ~clk;

    ep0_ctrl_status dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_setup_abort(ev_setup_abort), .ev_stall_sent(ev_stall_sent),
        .ev_in_sent(ev_in_sent), .ev_out_rcvd(ev_out_rcvd), .ev_data_done(ev_data_done),
        .stall_req(stall_req), .in_pkt_rdy(in_pkt_rdy), .data_end(data_end),
        .fifo_flush(fifo_flush), .ep_irq(ep_irq), .max_pkt(max_pkt)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: one update per rising edge, from the requirement text
    always @(posedge clk) begin
        if (!rst_n) begin
            m_send <= 0; m_setup <= 0; m_dend <= 0; m_sent <= 0;
            m_in <= 0; m_out <= 0; m_irq <= 0; m_flush <= 0; m_mps <= 0;
        end else begin
            bit w;
            w = reg_wr && !reg_sel;
            if (ev_setup_abort) m_setup <= 1; else if (w && reg_wdata[7]) m_setup <= 0;  // R3 R5 R10
            if (ev_out_rcvd) m_out <= 1; else if (w && reg_wdata[6]) m_out <= 0;         // R3 R9 R10
            if (w && reg_wdata[5]) m_send <= 1; else if (ev_stall_sent) m_send <= 0;     // R4
            if (w && reg_wdata[3]) m_dend <= 1; else if (ev_data_done) m_dend <= 0;      // R6
            if (ev_stall_sent) m_sent <= 1; else if (w && !reg_wdata[2]) m_sent <= 0;    // R7
            if (w && reg_wdata[1]) m_in <= 1; else if (ev_in_sent) m_in <= 0;            // R8
            m_irq <= ev_setup_abort || ev_stall_sent || ev_in_sent || ev_out_rcvd;       // R11
            m_flush <= ev_setup_abort;                                                    // R5
            if (reg_wr && reg_sel) m_mps <= reg_wdata;                                    // R12
        end
    end

    function automatic int exp_rdata();
        if (reg_sel) return m_mps;
        return (int'(m_send) << 5) | (int'(m_setup) << 4) | (int'(m_dend) << 3) |
               (int'(m_sent) << 2) | (int'(m_in) << 1) | int'(m_out);
    endfunction

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check("R2 rdata", reg_rdata, exp_rdata());
            check("R4 stall_req", stall_req, m_send);
            check("R6 data_end", data_end, m_dend);
            check("R8 in_pkt_rdy", in_pkt_rdy, m_in);
            check("R5 fifo_flush", fifo_flush, m_flush);
            check("R11 ep_irq", ep_irq, m_irq);
            check("R12 max_pkt", max_pkt, m_mps);
        end
    end

    // one stimulus cycle; on return the ports show its result
    // ev = {data_done, out_rcvd, in_sent, stall_sent, setup_abort}
    task automatic cyc(input bit wr, input bit sel, input logic [7:0] d, input logic [4:0] ev);
        @(posedge clk); #2;
        reg_wr = wr; reg_sel = sel; reg_wdata = d;
        {ev_data_done, ev_out_rcvd, ev_in_sent, ev_stall_sent, ev_setup_abort} = ev;
        @(posedge clk); #2;
        reg_wr = 0; reg_wdata = 8'h00;
        {ev_data_done, ev_out_rcvd, ev_in_sent, ev_stall_sent, ev_setup_abort} = 5'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        cmp_on = 1;
        @(posedge clk); #2;
        // R1: reset state
        check("R1 status", reg_rdata, 8'h00);
        check("R1 max_pkt", max_pkt, 0);
        check("R1 irq", ep_irq, 0);
        check("R1 stall_req", stall_req, 0);

        cyc(0, 0, 8'h00, 5'b01000);               // out packet received
        check("R9 out set", reg_rdata, 8'h01);
        check("R11 irq pulse", ep_irq, 1);
        @(posedge clk); #2;
        check("R11 irq single", ep_irq, 0);
        cyc(1, 0, 8'h01, 5'b0);
        check("R9 write bit0 keeps", reg_rdata, 8'h01);
        cyc(1, 0, 8'h40, 5'b0);
        check("R3 clear out", reg_rdata, 8'h00);
        cyc(1, 0, 8'h01, 5'b0);
        check("R9 write bit0 ignored", reg_rdata, 8'h00);

        cyc(0, 0, 8'h00, 5'b00001);               // early end of control transfer
        check("R5 setup set", reg_rdata, 8'h10);
        check("R5 flush pulse", fifo_flush, 1);
        cyc(1, 0, 8'h10, 5'b0);
        check("R5 write bit4 no effect", reg_rdata, 8'h10);
        cyc(1, 0, 8'h80, 5'b0);
        check("R3 clear setup", reg_rdata, 8'h00);

        cyc(1, 0, 8'h20, 5'b0);
        check("R4 stall armed", stall_req, 1);
        check("R2 send bit", reg_rdata, 8'h20);
        cyc(0, 0, 8'h00, 5'b00010);
        check("R4 stall done", stall_req, 0);
        check("R7 sent set", reg_rdata, 8'h04);
        cyc(1, 0, 8'h04, 5'b0);
        check("R7 write 1 keeps", reg_rdata, 8'h04);
        cyc(1, 0, 8'h00, 5'b0);
        check("R7 write 0 clears", reg_rdata, 8'h00);

        cyc(1, 0, 8'h44, 5'b01000);               // clear out + event together
        check("R10 out set wins", reg_rdata, 8'h01);
        cyc(1, 0, 8'h84, 5'b00001);
        check("R10 setup set wins", reg_rdata, 8'h11);
        cyc(1, 0, 8'h00, 5'b00010);
        check("R10 sent set wins", reg_rdata[2], 1);
        cyc(1, 0, 8'hC0, 5'b0);
        check("R3 both clears", reg_rdata, 8'h00);

        cyc(1, 0, 8'h02, 5'b0);
        check("R8 in set", in_pkt_rdy, 1);
        cyc(0, 0, 8'h00, 5'b00100);
        check("R8 in cleared", in_pkt_rdy, 0);
        check("R11 irq on in sent", ep_irq, 1);
        cyc(1, 0, 8'h0A, 5'b0);
        check("R6 data_end set", data_end, 1);
        cyc(0, 0, 8'h00, 5'b10000);
        check("R6 data_end cleared", data_end, 0);
        check("R11 no irq on data done", ep_irq, 0);
        cyc(1, 0, 8'h02, 5'b00100);
        check("R8 firmware set wins", in_pkt_rdy, 1);

        cyc(1, 1, 8'h08, 5'b0);
        check("R12 size loaded", max_pkt, 8);
        check("R12 size read", reg_rdata, 8);
        cyc(1, 0, 8'hFF, 5'b0);
        check("R12 status write keeps size", max_pkt, 8);

        cyc(0, 0, 8'h00, 5'b01111);
        check("R11 merged pulse", ep_irq, 1);
        @(posedge clk); #2;
        check("R11 merged single", ep_irq, 0);

        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #2;
            reg_wr = ($urandom % 3) == 0;
            reg_sel = ($urandom % 5) == 0;
            reg_wdata = 8'($urandom);
            ev_setup_abort = ($urandom % 9) == 0;
            ev_stall_sent = ($urandom % 7) == 0;
            ev_in_sent = ($urandom % 6) == 0;
            ev_out_rcvd = ($urandom % 6) == 0;
            ev_data_done = ($urandom % 5) == 0;
        end
        @(posedge clk); #2;
        reg_wr = 0;
        {ev_data_done, ev_out_rcvd, ev_in_sent, ev_stall_sent, ev_setup_abort} = 5'b0;
        repeat (2) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule